// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block sequences a supply-and-bus companion device through its operating modes: Off, Reset, Forced Normal, Normal, Standby, Sleep and Overtemp. It takes a 3-bit mode-control value written by software, wake-up event and enable vectors, a vector of event-status-pending flags, and single-bit power-on, undervoltage, external reset and overtemperature indications. It also takes two configuration bits: one that routes start-up into Forced Normal, and one that locks out Sleep. From these it computes the current mode, an active-low reset output, and enables for the main regulator, the auxiliary supply and the bus transceiver.

Entry to Sleep is guarded. A Sleep request with any event still pending, or with every wake-up source disabled, does not lower power. It forces a full pass through Reset instead. This keeps the device from falling asleep with no way to wake. Leaving Sleep, leaving Overtemp and recovering from any reset event all pass through Reset. Reset drives the reset output low for a programmable number of cycles and releases it before the block moves on.

All condition inputs are synchronous single-bit signals. Analog detection, the register interface and the watchdog sit outside this block.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_n` is low the block is in Off (`mode_o` = 0). In that state `rstn_o`, `reg_en_o`, `aux_en_o` and `xcvr_en_o` are all 0.
- R2: With `por_ok` high, Off moves to Reset after exactly STARTUP_CYC clock edges. When `por_ok` is low at a clock edge, the block goes to Off at that edge from any mode, and the start-up count begins again.
- R3: On entering Reset, `rstn_o` is held low for RST_PULSE_CYC edges and then goes high. One edge later the block leaves Reset for Forced Normal if `cfg_fnm` = 1, or for Standby otherwise. Either of these sends the block to Reset and restarts the pulse, in every mode except Off and Overtemp:
  - `ext_rst` high;
  - `v_uv` high while the regulator is enabled.
- R4: In Normal or Standby, a write (`mc_wr` = 1) of 3'b111 selects Normal and a write of 3'b100 selects Standby. A write of any other value except 3'b001 leaves the mode unchanged. Writes are ignored in Forced Normal, Reset, Sleep, Off and Overtemp.
- R5: A write of 3'b001 in Normal or Standby enters Sleep at the next edge when all three of these hold:
  - `evt_pend` is all zero;
  - at least one `wake_en` bit is 1;
  - `cfg_slp_lock` is 0.
- R6: A write of 3'b001 while any `evt_pend` bit is 1, or while every `wake_en` bit is 0, sends the block to Reset. This applies whatever the value of `cfg_slp_lock`.
- R7: A write of 3'b001 that R6 does not send to Reset leaves the mode unchanged when `cfg_slp_lock` = 1.
- R8: In Sleep, any `wake_evt` bit whose `wake_en` bit is 1 moves the block to Reset. `wake_evt` bits whose `wake_en` bit is 0 are ignored, and `v_uv` is ignored.
- R9: `otp` high at an edge moves the block to Overtemp (`mode_o` = 6) from every mode except Off and Sleep. The block stays in Overtemp while `otp` is high, ignoring `ext_rst`. It goes to Reset at the first edge with `otp` low.
- R10: The outputs follow the mode as below:
  - `reg_en_o` is 1 in Reset, Forced Normal, Normal and Standby.
  - `aux_en_o` is 1 in every mode except Off and Overtemp.
  - `xcvr_en_o` is 1 only in Forced Normal and Normal.
  - `rstn_o` is 1 only in Forced Normal, Normal and Standby, and during the last Reset cycle.
- R11: `mode_o` encodes the modes as Off = 0, Reset = 1, Forced Normal = 2, Normal = 3, Standby = 4, Sleep = 5, Overtemp = 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| por_ok | input | 1 | Battery supply above the power-on threshold |
| v_uv | input | 1 | Regulator output undervoltage |
| ext_rst | input | 1 | Other system reset event |
| otp | input | 1 | Overtemperature indication |
| cfg_fnm | input | 1 | Leave Reset into Forced Normal |
| cfg_slp_lock | input | 1 | Block Sleep requests |
| mc_wr | input | 1 | Mode-control write strobe |
| mc_val | input | 3 | Mode-control value |
| wake_evt | input | WAKE_SRC | Wake-up event flags |
| wake_en | input | WAKE_SRC | Wake-up source enables |
| evt_pend | input | EVT_BITS | Event status pending flags |
| mode_o | output | 3 | Current mode |
| rstn_o | output | 1 | Active-low reset request |
| reg_en_o | output | 1 | Main regulator enable |
| aux_en_o | output | 1 | Auxiliary supply enable |
| xcvr_en_o | output | 1 | Transceiver enable |

## Verification
The Sleep request is tried under four input patterns:
- all guards satisfied;
- an event pending;
- every wake source disabled;
- the lock bit set on an otherwise valid request.

Together these separate the three outcomes: sleep, reset and ignore. A second pass sets the lock together with disabled sources, to show that the reset outcome wins over the lock. In Sleep, the bench presents a disabled wake bit before an enabled one, and an undervoltage pulse, to show that only qualified wake events end Sleep. The bench drives reset events and overtemperature from several modes, including a reset event in the middle of a Reset pulse. This separates restarting the pulse from continuing it, and shows that overtemperature takes precedence over reset events and is ignored in Sleep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        MODE_OFF     = 3'd0,
        MODE_RESET   = 3'd1,
        MODE_FNORM   = 3'd2,
        MODE_NORMAL  = 3'd3,
        MODE_STANDBY = 3'd4,
        MODE_SLEEP   = 3'd5,
        MODE_OTEMP   = 3'd6
    } mode_e;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_NORMAL,
        REQ_STANDBY,
        REQ_SLEEP
    } req_e;

    localparam logic [2:0] MC_NORMAL  = 3'b111;
    localparam logic [2:0] MC_STANDBY = 3'b100;
    localparam logic [2:0] MC_SLEEP   = 3'b001;

endpackage

// File: rtl/lpm_cmd_decode.sv
module lpm_cmd_decode
    import lpm_pkg::*;
(
    input  logic       mc_wr,
    input  logic [2:0] mc_val,
    input  logic       accept,
    output req_e       req
);

    always_comb begin
        req = REQ_NONE;
        if (mc_wr && accept) begin
            case (mc_val)
                MC_NORMAL:  req = REQ_NORMAL;
                MC_STANDBY: req = REQ_STANDBY;
                MC_SLEEP:   req = REQ_SLEEP;
                default:    req = REQ_NONE;
            endcase
        end
    end

endmodule

// File: rtl/lpm_sleep_gate.sv
module lpm_sleep_gate #(
    parameter int WAKE_SRC = 2,
    parameter int EVT_BITS = 4
) (
    input  logic                req_sleep,
    input  logic [EVT_BITS-1:0] evt_pend,
    input  logic [WAKE_SRC-1:0] wake_en,
    input  logic                lock,
    output logic                sleep_go,
    output logic                sleep_rst
);

    logic any_pend;
    logic none_en;

    always_comb begin
        any_pend  = |evt_pend;
        none_en   = ~|wake_en;
        // unsafe request wins over the lock
        sleep_rst = req_sleep && (any_pend || none_en);
        sleep_go  = req_sleep && !any_pend && !none_en && !lock;
    end

endmodule

// File: rtl/lpm_rail_map.sv
module lpm_rail_map
    import lpm_pkg::*;
(
    input  mode_e mode,
    output logic  reg_en,
    output logic  aux_en,
    output logic  xcvr_en
);

    always_comb begin
        reg_en  = 1'b0;
        aux_en  = 1'b0;
        xcvr_en = 1'b0;
        case (mode)
            MODE_RESET, MODE_STANDBY: begin
                reg_en = 1'b1;
                aux_en = 1'b1;
            end
            MODE_FNORM, MODE_NORMAL: begin
                reg_en  = 1'b1;
                aux_en  = 1'b1;
                xcvr_en = 1'b1;
            end
            MODE_SLEEP: aux_en = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int STARTUP_CYC   = 20,
    parameter int RST_PULSE_CYC = 8,
    parameter int WAKE_SRC      = 2,
    parameter int EVT_BITS      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_ok,
    input  logic                v_uv,
    input  logic                ext_rst,
    input  logic                otp,
    input  logic                cfg_fnm,
    input  logic                cfg_slp_lock,
    input  logic                mc_wr,
    input  logic [2:0]          mc_val,
    input  logic [WAKE_SRC-1:0] wake_evt,
    input  logic [WAKE_SRC-1:0] wake_en,
    input  logic [EVT_BITS-1:0] evt_pend,
    output logic [2:0]          mode_o,
    output logic                rstn_o,
    output logic                reg_en_o,
    output logic                aux_en_o,
    output logic                xcvr_en_o
);

    localparam int CNT_MAX = (STARTUP_CYC > RST_PULSE_CYC) ? STARTUP_CYC : RST_PULSE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(STARTUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(RST_PULSE_CYC - 1);

    typedef struct packed {
        mode_e            mode;
        logic [CNT_W-1:0] cnt;
        logic             rstn;
    } state_t;

    state_t st_d, st_q;

    logic [WAKE_SRC-1:0] wake_hit;
    logic                reg_en;
    logic                aux_en;
    logic                xcvr_en;
    logic                accept;
    logic                sleep_go;
    logic                sleep_rst;
    logic                rst_evt;
    req_e                req;

    // qualify each wake source by its enable
    for (genvar g = 0; g < WAKE_SRC; g++) begin : g_wake
        assign wake_hit[g] = wake_evt[g] & wake_en[g];
    end

    assign accept = (st_q.mode == MODE_NORMAL) || (st_q.mode == MODE_STANDBY);

    lpm_cmd_decode u_cmd (
        .mc_wr  (mc_wr),
        .mc_val (mc_val),
        .accept (accept),
        .req    (req)
    );

    lpm_sleep_gate #(
        .WAKE_SRC (WAKE_SRC),
        .EVT_BITS (EVT_BITS)
    ) u_gate (
        .req_sleep (req == REQ_SLEEP),
        .evt_pend  (evt_pend),
        .wake_en   (wake_en),
        .lock      (cfg_slp_lock),
        .sleep_go  (sleep_go),
        .sleep_rst (sleep_rst)
    );

    lpm_rail_map u_rail (
        .mode    (st_q.mode),
        .reg_en  (reg_en),
        .aux_en  (aux_en),
        .xcvr_en (xcvr_en)
    );

    assign rst_evt = ext_rst || (v_uv && reg_en);

    function automatic state_t enter_reset();
        state_t s;
        s.mode = MODE_RESET;
        s.cnt  = '0;
        s.rstn = 1'b0;
        return s;
    endfunction

    always_comb begin
        st_d = st_q;
        if (!por_ok) begin
            st_d.mode = MODE_OFF;
            st_d.cnt  = '0;
        end else begin
            case (st_q.mode)
                MODE_OFF: begin
                    if (st_q.cnt == START_LAST) st_d = enter_reset();
                    else                        st_d.cnt = st_q.cnt + 1'b1;
                end
                MODE_OTEMP: begin
                    if (!otp) st_d = enter_reset();
                end
                default: begin
                    if (otp && st_q.mode != MODE_SLEEP) begin
                        st_d.mode = MODE_OTEMP;
                    end else if (rst_evt) begin
                        st_d = enter_reset();
                    end else begin
                        case (st_q.mode)
                            MODE_RESET: begin
                                if (st_q.rstn) begin
                                    st_d.mode = cfg_fnm ? MODE_FNORM : MODE_STANDBY;
                                end else begin
                                    st_d.cnt = st_q.cnt + 1'b1;
                                    if (st_q.cnt == PULSE_LAST) st_d.rstn = 1'b1;
                                end
                            end
                            MODE_NORMAL, MODE_STANDBY: begin
                                if (sleep_rst)                st_d = enter_reset();
                                else if (sleep_go)            st_d.mode = MODE_SLEEP;
                                else if (req == REQ_NORMAL)   st_d.mode = MODE_NORMAL;
                                else if (req == REQ_STANDBY)  st_d.mode = MODE_STANDBY;
                            end
                            MODE_SLEEP: begin
                                if (|wake_hit) st_d = enter_reset();
                            end
                            default: ;
                        endcase
                    end
                end
            endcase
        end
        if (st_d.mode != MODE_RESET) begin
            st_d.rstn = (st_d.mode == MODE_FNORM) || (st_d.mode == MODE_NORMAL) ||
                        (st_d.mode == MODE_STANDBY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_OFF;
            st_q.cnt  <= '0;
            st_q.rstn <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign rstn_o    = st_q.rstn;
    assign reg_en_o  = reg_en;
    assign aux_en_o  = aux_en;
    assign xcvr_en_o = xcvr_en;

    // R2
    por_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> st_q.mode == MODE_OFF);

    // R3
    reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RESET && !st_q.rstn) |=>
            (st_q.mode != MODE_FNORM && st_q.mode != MODE_STANDBY));

    // R5
    sleep_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_SLEEP && $past(st_q.mode) != MODE_SLEEP) |->
            ($past(evt_pend) == '0 && $past(wake_en) != '0 && !$past(cfg_slp_lock)));

    // R8
    sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_SLEEP && wake_hit != '0 && por_ok) |=> st_q.mode == MODE_RESET);

    // R9
    otemp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (otp && por_ok && st_q.mode != MODE_OFF && st_q.mode != MODE_SLEEP) |=>
            st_q.mode == MODE_OTEMP);

    // R10
    xcvr_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_en |-> st_q.rstn);

endmodule

// File: tb/lpm_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpm_ctrl_tb_top;

    localparam int S = 20;
    localparam int P = 8;

    logic       clk = 1'b0;
    logic       rst_n, por_ok, v_uv, ext_rst, otp, cfg_fnm, cfg_slp_lock, mc_wr;
    logic [2:0] mc_val;
    logic [1:0] wake_evt, wake_en;
    logic [3:0] evt_pend;
    logic [2:0] mode_o;
    logic       rstn_o, reg_en_o, aux_en_o, xcvr_en_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lpm_ctrl #(
        .STARTUP_CYC   (S),
        .RST_PULSE_CYC (P),
        .WAKE_SRC      (2),
        .EVT_BITS      (4)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .por_ok (por_ok), .v_uv (v_uv),
        .ext_rst (ext_rst), .otp (otp), .cfg_fnm (cfg_fnm),
        .cfg_slp_lock (cfg_slp_lock), .mc_wr (mc_wr), .mc_val (mc_val),
        .wake_evt (wake_evt), .wake_en (wake_en), .evt_pend (evt_pend),
        .mode_o (mode_o), .rstn_o (rstn_o), .reg_en_o (reg_en_o),
        .aux_en_o (aux_en_o), .xcvr_en_o (xcvr_en_o)
    );

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_mc(input logic [2:0] v);
        mc_val = v;
        mc_wr  = 1'b1;
        step();
        mc_wr  = 1'b0;
    endtask

    // block has just entered Reset; run the pulse out and check the exit
    task automatic recover(input int exp_mode);
        step(P - 1);
        chk("R3 rstn low during pulse", rstn_o, 0);
        step();
        chk("R3 rstn released in reset", rstn_o, 1);
        chk("R3 still in reset at release", mode_o, 1);
        step();
        chk("R3 exit mode", mode_o, exp_mode);
    endtask

    task automatic bring_up(input bit fnm);
        cfg_fnm = fnm;
        rst_n   = 1'b0;
        por_ok  = 1'b1;
        step(2);
        chk("R1 mode off in reset", mode_o, 0);
        chk("R1 rstn low", rstn_o, 0);
        chk("R1 rails off", {reg_en_o, aux_en_o, xcvr_en_o}, 0);
        rst_n = 1'b1;
        step(S - 1);
        chk("R2 still off before startup count", mode_o, 0);
        step();
        chk("R2 reset after startup", mode_o, 1);
        chk("R10 reg on in reset", reg_en_o, 1);
        chk("R10 xcvr off in reset", xcvr_en_o, 0);
        recover(fnm ? 2 : 4);
    endtask

    task automatic t_mode_ctrl();
        bring_up(1'b0);
        write_mc(3'b111);
        chk("R4 normal selected", mode_o, 3);
        chk("R10 xcvr on in normal", xcvr_en_o, 1);
        write_mc(3'b010);
        chk("R4 unlisted code ignored", mode_o, 3);
        write_mc(3'b100);
        chk("R4 standby selected", mode_o, 4);
        chk("R10 xcvr off in standby", xcvr_en_o, 0);
        chk("R10 rstn high in standby", rstn_o, 1);
    endtask

    task automatic t_fnorm();
        bring_up(1'b1);
        chk("R10 xcvr on in forced normal", xcvr_en_o, 1);
        write_mc(3'b100);
        chk("R4 write ignored in forced normal", mode_o, 2);
        wake_en = 2'b01;
        write_mc(3'b001);
        chk("R4 sleep write ignored in forced normal", mode_o, 2);
    endtask

    task automatic t_sleep_ok();
        bring_up(1'b0);
        wake_en  = 2'b01;
        evt_pend = 4'b0000;
        write_mc(3'b001);
        chk("R5 sleep entered", mode_o, 5);
        chk("R10 reg off in sleep", reg_en_o, 0);
        chk("R10 aux on in sleep", aux_en_o, 1);
        chk("R10 rstn low in sleep", rstn_o, 0);
        write_mc(3'b111);
        chk("R4 write ignored in sleep", mode_o, 5);
        v_uv = 1'b1;
        step();
        v_uv = 1'b0;
        chk("R8 undervoltage ignored in sleep", mode_o, 5);
        otp = 1'b1;
        step();
        otp = 1'b0;
        chk("R9 overtemp ignored in sleep", mode_o, 5);
        wake_evt = 2'b10;
        step();
        chk("R8 disabled wake ignored", mode_o, 5);
        wake_evt = 2'b01;
        step();
        wake_evt = 2'b00;
        chk("R8 enabled wake leads to reset", mode_o, 1);
        recover(4);
    endtask

    task automatic t_sleep_refused();
        bring_up(1'b0);
        wake_en  = 2'b11;
        evt_pend = 4'b0100;
        write_mc(3'b001);
        evt_pend = 4'b0000;
        chk("R6 pending event gives reset", mode_o, 1);
        recover(4);
        wake_en      = 2'b00;
        cfg_slp_lock = 1'b1;
        write_mc(3'b001);
        chk("R6 no wake source gives reset over lock", mode_o, 1);
        recover(4);
        wake_en = 2'b10;
        write_mc(3'b111);
        write_mc(3'b001);
        chk("R7 locked sleep request ignored", mode_o, 3);
        cfg_slp_lock = 1'b0;
    endtask

    task automatic t_otemp();
        bring_up(1'b0);
        write_mc(3'b111);
        otp = 1'b1;
        step();
        chk("R9 overtemp entered", mode_o, 6);
        chk("R10 all rails off in overtemp", {reg_en_o, aux_en_o, xcvr_en_o}, 0);
        chk("R10 rstn low in overtemp", rstn_o, 0);
        ext_rst = 1'b1;
        step();
        ext_rst = 1'b0;
        chk("R9 reset event ignored in overtemp", mode_o, 6);
        otp = 1'b0;
        step();
        chk("R9 overtemp exits to reset", mode_o, 1);
        recover(4);
    endtask

    task automatic t_rst_evt();
        bring_up(1'b0);
        ext_rst = 1'b1;
        step();
        ext_rst = 1'b0;
        chk("R3 external reset event", mode_o, 1);
        chk("R3 rstn low after reset event", rstn_o, 0);
        step(3);
        v_uv = 1'b1;
        step();
        v_uv = 1'b0;
        chk("R3 undervoltage restarts pulse", mode_o, 1);
        recover(4);
    endtask

    task automatic t_por_drop();
        bring_up(1'b0);
        write_mc(3'b111);
        por_ok = 1'b0;
        step();
        chk("R2 power loss gives off", mode_o, 0);
        chk("R10 rails off in off", {reg_en_o, aux_en_o, xcvr_en_o}, 0);
        step(3);
        por_ok = 1'b1;
        step(S - 1);
        chk("R2 startup count restarted", mode_o, 0);
        step();
        chk("R2 reset after restart", mode_o, 1);
        chk("R11 reset code", mode_o, 1);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; por_ok = 1'b1; v_uv = 1'b0; ext_rst = 1'b0; otp = 1'b0;
        cfg_fnm = 1'b0; cfg_slp_lock = 1'b0; mc_wr = 1'b0; mc_val = 3'b000;
        wake_evt = 2'b00; wake_en = 2'b00; evt_pend = 4'b0000;
        @(negedge clk);
        t_mode_ctrl();
        t_fnorm();
        t_sleep_ok();
        t_sleep_refused();
        t_otemp();
        t_rst_evt();
        t_por_drop();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule